// File: doc/BRIEF.md
# Processor State Viewer with Hex Display and Step Clock

This block lets a user look inside a small processor while it runs or while it is stepped by hand. A two-bit source selector chooses one of four state sources: the instruction store, the general register file, the multiply/divide result pair, or the data store. An index then picks one 32-bit word from that source. The word is decoded with no clock into eight seven-segment digit patterns, so the whole word shows as eight hex digits.

The block also makes the processor clock. A mode switch chooses between free-running operation, where the processor receives the system clock unchanged, and stepping operation. In stepping mode the processor clock stays low, and each clean press of a push button gives exactly one clock pulse. The button passes through a two-flop synchroniser and a debounce counter, so contact bounce and short glitches give no pulses.

Top module: `dbg_hex_view`

## Requirements
- R1: With selector 0 and index i below the instruction store size, the displayed word is instruction word i, taken from bits [32*i+31:32*i] of the flattened bus.
- R2: With selector 1 and index i below the register count, the displayed word is register i, taken from the same position in the register bus.
- R3: With selector 2, index 0 displays the HI word and index 1 displays the LO word.
- R4: With selector 3 and index i below the data store size, the displayed word is data word i.
- R5: An index at or beyond the size of the selected source (the size is 2 for selector 2) displays the word 0, which shows as eight "0" glyphs.
- R6: Digit k shows word bits [4k+3:4k]. Each pattern is 7 bits, active low, with bit 6 = segment g down to bit 0 = segment a, and uses the usual hex glyphs: 0 -> 7'h40, 1 -> 7'h79, 8 -> 7'h00, F -> 7'h0E (lower-case b and d).
- R7: The display follows the selector, index and state inputs with no clock edge between a change and its effect.
- R8: When the synchronised mode switch is 1 (run), the processor clock output gives one rising edge for each system clock cycle.
- R9: When the mode switch is 0 (step), each press held longer than the debounce window gives exactly one processor clock pulse, one system cycle wide. Keeping the button held and then releasing it gives no further pulses.
- R10: A button level that lasts fewer cycles than the debounce window gives no pulse.
- R11: During reset and just after it, the mode is step, no pulse is pending, and the processor clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, full rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_i | input | IMEM_WORDS*32 | Flattened instruction store words, word 0 in the low bits |
| gpr_i | input | NREG*32 | Flattened general register file |
| hi_i | input | 32 | Multiply/divide HI result |
| lo_i | input | 32 | Multiply/divide LO result |
| dmem_i | input | DMEM_WORDS*32 | Flattened data store words |
| sel_i | input | 2 | Source: 0 instr, 1 regs, 2 HI/LO, 3 data |
| idx_i | input | IDX_W | Entry index within the selected source |
| run_i | input | 1 | Mode switch: 1 run, 0 step |
| btn_i | input | 1 | Raw step push button, active high |
| seg_o | output | 56 | Eight digit patterns, digit k at [7k+6:7k] |
| proc_clk_o | output | 1 | Clock for the processor |

## Verification
The bench walks each source, using words that together contain all sixteen hex digits. A swapped nibble order or a wrong glyph therefore shows as a mismatch on a named digit. It probes the first index past the end of each source. A design that lets the index wrap, or that reads past the flattened bus, would show a real word or X instead of zeros. The bench also gives a glitch shorter than the debounce window, a long hold and a release, and counts processor clock edges in each case. A missing debounce gives an extra pulse, and a level-driven step clock gives a wide pulse or a pulse on release.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    SRC_IMEM = 2'd0,
    SRC_GPR  = 2'd1,
    SRC_HILO = 2'd2,
    SRC_DMEM = 2'd3
  } src_e;

  // active-low, bit6=g .. bit0=a
  function automatic logic [6:0] nib_to_seg(input logic [3:0] n);
    logic [6:0] on;
    case (n)
      4'h0: on = 7'h3F;
      4'h1: on = 7'h06;
      4'h2: on = 7'h5B;
      4'h3: on = 7'h4F;
      4'h4: on = 7'h66;
      4'h5: on = 7'h6D;
      4'h6: on = 7'h7D;
      4'h7: on = 7'h07;
      4'h8: on = 7'h7F;
      4'h9: on = 7'h6F;
      4'hA: on = 7'h77;
      4'hB: on = 7'h7C;
      4'hC: on = 7'h39;
      4'hD: on = 7'h5E;
      4'hE: on = 7'h79;
      default: on = 7'h71;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/dbg_word_mux.sv
module dbg_word_mux
  import dbg_pkg::*;
#(
  parameter int IMEM_WORDS = 16,
  parameter int NREG       = 32,
  parameter int DMEM_WORDS = 16,
  parameter int IDX_W      = 8,
  parameter int W          = 32
) (
  input  logic [IMEM_WORDS*W-1:0] imem_i,
  input  logic [NREG*W-1:0]       gpr_i,
  input  logic [W-1:0]            hi_i,
  input  logic [W-1:0]            lo_i,
  input  logic [DMEM_WORDS*W-1:0] dmem_i,
  input  logic [1:0]              sel_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [W-1:0]            word_o
);
  logic [31:0] idx_ext;
  assign idx_ext = 32'(idx_i);

  always_comb begin
    word_o = '0;
    case (src_e'(sel_i))
      SRC_IMEM: if (idx_ext < 32'(IMEM_WORDS)) word_o = imem_i[idx_ext*W +: W];
      SRC_GPR:  if (idx_ext < 32'(NREG))       word_o = gpr_i[idx_ext*W +: W];
      SRC_HILO: begin
        if (idx_ext == 32'd0)      word_o = hi_i;
        else if (idx_ext == 32'd1) word_o = lo_i;
      end
      default:  if (idx_ext < 32'(DMEM_WORDS)) word_o = dmem_i[idx_ext*W +: W];
    endcase
  end
endmodule

// File: rtl/dbg_hex7.sv
module dbg_hex7
  import dbg_pkg::*;
(
  input  logic [3:0] nib_i,
  output logic [6:0] seg_o
);
  assign seg_o = nib_to_seg(nib_i);
endmodule

// File: rtl/dbg_step_clk.sv
module dbg_step_clk #(
  parameter int DEB_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic btn_i,
  output logic run_o,
  output logic btn_s_o,
  output logic deb_o,
  output logic step_o,
  output logic proc_clk_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          b_meta, b_sync, r_meta, r_sync, deb_q, step_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_meta <= 1'b0;
      b_sync <= 1'b0;
      r_meta <= 1'b0;
      r_sync <= 1'b0;
      deb_q  <= 1'b0;
      step_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      b_meta <= btn_i;
      b_sync <= b_meta;
      r_meta <= run_i;
      r_sync <= r_meta;
      step_q <= 1'b0;
      if (b_sync == deb_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
        cnt_q  <= '0;
        deb_q  <= b_sync;
        step_q <= b_sync;  // pulse on debounced press only
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign proc_clk_o = r_sync ? clk_i : step_q;
  assign run_o      = r_sync;
  assign btn_s_o    = b_sync;
  assign deb_o      = deb_q;
  assign step_o     = step_q;
endmodule

// File: rtl/dbg_hex_view.sv
module dbg_hex_view #(
  parameter int IMEM_WORDS = 16,
  parameter int NREG       = 32,
  parameter int DMEM_WORDS = 16,
  parameter int IDX_W      = 8,
  parameter int DEB_CYCLES = 4096
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IMEM_WORDS*32-1:0] imem_i,
  input  logic [NREG*32-1:0]       gpr_i,
  input  logic [31:0]              hi_i,
  input  logic [31:0]              lo_i,
  input  logic [DMEM_WORDS*32-1:0] dmem_i,
  input  logic [1:0]               sel_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     run_i,
  input  logic                     btn_i,
  output logic [55:0]              seg_o,
  output logic                     proc_clk_o
);
  localparam int W      = 32;
  localparam int DIGITS = W / 4;

  logic [W-1:0] word;
  logic         run_q, btn_s, deb_q, step_q;

  dbg_word_mux #(
    .IMEM_WORDS(IMEM_WORDS), .NREG(NREG), .DMEM_WORDS(DMEM_WORDS),
    .IDX_W(IDX_W), .W(W)
  ) u_mux (
    .imem_i(imem_i), .gpr_i(gpr_i), .hi_i(hi_i), .lo_i(lo_i),
    .dmem_i(dmem_i), .sel_i(sel_i), .idx_i(idx_i), .word_o(word)
  );

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    dbg_hex7 u_hex (.nib_i(word[4*g +: 4]), .seg_o(seg_o[7*g +: 7]));
  end

  dbg_step_clk #(.DEB_CYCLES(DEB_CYCLES)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .btn_i(btn_i),
    .run_o(run_q), .btn_s_o(btn_s), .deb_o(deb_q), .step_o(step_q),
    .proc_clk_o(proc_clk_o)
  );
endmodule

// File: rtl/dbg_hex_view_chk.sv
module dbg_hex_view_chk #(
  parameter int NREG  = 32,
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [31:0]      hi_i,
  input logic [31:0]      lo_i,
  input logic [31:0]      word,
  input logic             run_q,
  input logic             btn_s,
  input logic             deb_q,
  input logic             step_q,
  input logic             proc_clk_o
);
  p_hi_view_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd2 && idx_i == '0) |-> word == hi_i);

  p_lo_view_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd2 && 32'(idx_i) == 32'd1) |-> word == lo_i);

  p_gpr_oor_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1 && 32'(idx_i) >= 32'(NREG)) |-> word == '0);

  p_step_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |=> !step_q);

  p_step_on_press_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_q) |-> deb_q);

  p_deb_follows_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(deb_q) |-> deb_q == $past(btn_s));

  p_step_idle_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !step_q) |-> !proc_clk_o);
endmodule

bind dbg_hex_view dbg_hex_view_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .idx_i(idx_i),
  .hi_i(hi_i), .lo_i(lo_i), .word(word), .run_q(run_q), .btn_s(btn_s),
  .deb_q(deb_q), .step_q(step_q), .proc_clk_o(proc_clk_o)
);

// File: tb/sim_dbg_hex_view.sv
`timescale 1ns/1ps
module sim_dbg_hex_view;
  localparam int IMEM_WORDS = 16;
  localparam int NREG       = 32;
  localparam int DMEM_WORDS = 8;
  localparam int IDX_W      = 6;
  localparam int DEB_CYCLES = 16;

  typedef struct {
    string       tag;
    logic [31:0] word;
  } item_t;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [IMEM_WORDS*32-1:0] imem;
  logic [NREG*32-1:0]       gpr;
  logic [31:0]              hi, lo;
  logic [DMEM_WORDS*32-1:0] dmem;
  logic [1:0]               sel = '0;
  logic [IDX_W-1:0]         idx = '0;
  logic                     run = 1'b0;
  logic                     btn = 1'b0;
  logic [55:0]              seg;
  logic                     pclk;

  int n_chk = 0, n_bad = 0, pedges = 0;
  bit done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge pclk) pedges++;

  dbg_hex_view #(
    .IMEM_WORDS(IMEM_WORDS), .NREG(NREG), .DMEM_WORDS(DMEM_WORDS),
    .IDX_W(IDX_W), .DEB_CYCLES(DEB_CYCLES)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .imem_i(imem), .gpr_i(gpr), .hi_i(hi),
    .lo_i(lo), .dmem_i(dmem), .sel_i(sel), .idx_i(idx), .run_i(run),
    .btn_i(btn), .seg_o(seg), .proc_clk_o(pclk)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] n);
    logic [6:0] lit;
    case (n)
      4'h0: lit = 7'b0111111; 4'h1: lit = 7'b0000110;
      4'h2: lit = 7'b1011011; 4'h3: lit = 7'b1001111;
      4'h4: lit = 7'b1100110; 4'h5: lit = 7'b1101101;
      4'h6: lit = 7'b1111101; 4'h7: lit = 7'b0000111;
      4'h8: lit = 7'b1111111; 4'h9: lit = 7'b1101111;
      4'hA: lit = 7'b1110111; 4'hB: lit = 7'b1111100;
      4'hC: lit = 7'b0111001; 4'hD: lit = 7'b1011110;
      4'hE: lit = 7'b1111001; default: lit = 7'b1110001;
    endcase
    return ~lit;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: change view between edges, queue the expected word
  task automatic view(input string tag, input logic [1:0] s, input int i, input logic [31:0] w);
    item_t it;
    @(posedge clk); #0.5;
    sel = s;
    idx = IDX_W'(i);
    it.tag = tag;
    it.word = w;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // monitor: sample before the next clock edge (R7)
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      #1.0;
      it = q[0];
      for (int d = 0; d < 8; d++) begin
        logic [6:0] e;
        e = exp_seg(it.word[4*d +: 4]);
        n_chk++;
        if (seg[7*d +: 7] !== e) begin
          n_bad++;
          $display("FAIL %s R6 R7 digit %0d actual=%h expected=%h", it.tag, d, seg[7*d +: 7], e);
        end
      end
      void'(q.pop_front());
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] iw(input int i); return 32'h0123_4567 + 32'(i) * 32'h1111_1111; endfunction
  function automatic logic [31:0] rw(input int i); return 32'h89AB_CDEF ^ (32'(i) * 32'h0F0F_1234); endfunction
  function automatic logic [31:0] dw(input int i); return ~(32'(i) * 32'h1357_9BDF); endfunction

  initial begin
    int p0;
    for (int i = 0; i < IMEM_WORDS; i++) imem[32*i +: 32] = iw(i);
    for (int i = 0; i < NREG; i++) gpr[32*i +: 32] = rw(i);
    for (int i = 0; i < DMEM_WORDS; i++) dmem[32*i +: 32] = dw(i);
    hi = 32'hFEDC_BA98;
    lo = 32'h7654_3210;

    repeat (3) @(negedge clk);
    check("R11 clock low in reset", pclk === 1'b0, int'(pclk), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 clock low after reset", pclk === 1'b0, int'(pclk), 0);

    view("R1 imem 0", 2'd0, 0, iw(0));
    view("R1 imem 5", 2'd0, 5, iw(5));
    view("R1 imem last", 2'd0, IMEM_WORDS - 1, iw(IMEM_WORDS - 1));
    view("R5 imem past end", 2'd0, IMEM_WORDS, 32'h0);
    view("R2 reg 0", 2'd1, 0, rw(0));
    view("R2 reg 17", 2'd1, 17, rw(17));
    view("R2 reg last", 2'd1, NREG - 1, rw(NREG - 1));
    view("R5 reg past end", 2'd1, NREG, 32'h0);
    view("R3 hi", 2'd2, 0, hi);
    view("R3 lo", 2'd2, 1, lo);
    view("R5 hilo index 2", 2'd2, 2, 32'h0);
    view("R4 dmem 3", 2'd3, 3, dw(3));
    view("R4 dmem last", 2'd3, DMEM_WORDS - 1, dw(DMEM_WORDS - 1));
    view("R5 dmem past end", 2'd3, DMEM_WORDS, 32'h0);
    view("R5 dmem max index", 2'd3, (1 << IDX_W) - 1, 32'h0);

    // R7: state input change with no edge between
    @(posedge clk); #0.5;
    sel = 2'd2; idx = '0; hi = 32'h0F1E_2D3C;
    begin item_t it; it.tag = "R7 hi live"; it.word = 32'h0F1E_2D3C; q.push_back(it); end
    wait (q.size() == 0);

    // R10: short glitch, step mode
    @(negedge clk); p0 = pedges;
    btn = 1'b1; repeat (5) @(negedge clk); btn = 1'b0;
    repeat (40) @(negedge clk);
    check("R10 glitch gives no pulse", pedges == p0, pedges - p0, 0);

    // R9: press and hold, then release
    p0 = pedges;
    btn = 1'b1; repeat (60) @(negedge clk);
    check("R9 held press one pulse", pedges - p0 == 1, pedges - p0, 1);
    p0 = pedges;
    btn = 1'b0; repeat (40) @(negedge clk);
    check("R9 release no pulse", pedges == p0, pedges - p0, 0);
    p0 = pedges;
    btn = 1'b1; repeat (40) @(negedge clk); btn = 1'b0; repeat (40) @(negedge clk);
    check("R9 second press one pulse", pedges - p0 == 1, pedges - p0, 1);

    // R8: run mode
    run = 1'b1; repeat (6) @(negedge clk);
    p0 = pedges;
    repeat (20) @(negedge clk);
    check("R8 run edges per cycle", pedges - p0 == 20, pedges - p0, 20);
    run = 1'b0; repeat (6) @(negedge clk);
    p0 = pedges;
    repeat (20) @(negedge clk);
    check("R9 step mode idle", pedges == p0, pedges - p0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule